// File: doc/BRIEF.md
# Flat-Panel Link Serializer, Three Data Lanes plus Forwarded Clock

This block sits at the transmit end of a flat-panel display link. Once per pixel period it takes a 21-bit parallel word and sends it out over three serial data lanes, seven bits per lane per period. The word holds 18 colour bits and three timing bits: line sync, frame sync and data-ready. A fourth lane sends a fixed seven-slot clock pattern. The far end uses this pattern to find word boundaries.

Everything runs in one clock domain. `clk` is the bit clock, and one pixel period is seven `clk` cycles. The block generates the pixel clock `pix_clk_o` for the upstream source. A strap input picks whether the parallel word is sampled where that pixel clock rises or where it falls. While power-down is active, the output enable is dropped, every lane is driven low and the lock indication is cleared. When power-down is released, the `locked_o` status stays low until a set number of full pixel periods has gone by.

Top module: `fpd_link_serializer`

## Requirements
- R1: While `rst` is high, and on the first clock after reset, every lane output is 0, `lane_oe_o` is 0, `locked_o` is 0 and `pix_clk_o` is 1.
- R2: Within a pixel period, slot s (s = 0..6, counted from the cycle in which `pix_clk_o` becomes 1) carries bit s of that lane's seven-bit group. Bit 0 goes first.
- R3: `data_lane_o[0]` carries word bits 0..6, `data_lane_o[1]` carries bits 7..13 and `data_lane_o[2]` carries bits 14..20. Bits 18, 19 and 20 are line sync, frame sync and data-ready.
- R4: From the first pixel period after reset or power-down onward, `clk_lane_o` sends 1,1,0,0,0,1,1 in slots 0..6. Before that it is 0.
- R5: With `edge_sel_i` = 0 (rising), the word present on `pix_word_i` in the cycle just before `pix_clk_o` becomes 1 is captured. It is sent in the pixel period that starts seven cycles later.
- R6: With `edge_sel_i` = 1 (falling), the word present in the cycle just before `pix_clk_o` becomes 0 is captured. It is sent in the pixel period that starts three cycles later.
- R7: `pix_clk_o` is 1 in slots 0..3 and 0 in slots 4..6. Its period is seven `clk` cycles.
- R8: In the clock after `pd_i` is sampled high, `lane_oe_o` and all lanes are 0. After release, slot counting restarts from slot 0. Until the first load, the captured word and the frame being sent are zero.
- R9: `locked_o` rises at the end of the LOCK_PERIODS-th full pixel period after reset or power-down release. It then stays high until reset or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| pd_i | input | 1 | Power-down request |
| edge_sel_i | input | 1 | Capture edge strap: 0 rising, 1 falling |
| pix_word_i | input | 21 | Parallel pixel word |
| data_lane_o | output | 3 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded clock lane |
| lane_oe_o | output | 1 | Lane output enable (low means high impedance) |
| pix_clk_o | output | 1 | Pixel clock for the upstream source |
| locked_o | output | 1 | Output-valid status after the lock interval |

## Verification
A slot counter that is off by one moves the edge of `pix_clk_o` and rotates every lane's bit order in the same cycle. A fault like that shows at the ports within seven clocks. A wrong capture point or a stale capture register does not show until the following pixel period, when the word appears on the data lanes. Changing the input word every cycle makes each capture point select a different value. A wrong lock count only shows at the single cycle where `locked_o` rises, so power-down is cycled several times to reach that cycle more than once.

// File: rtl/fpd_ser_pkg.sv
package fpd_ser_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_mode_e;

  // Number of slots per pixel period in which the pixel clock is high.
  function automatic int unsigned high_slots(input int unsigned bits);
    return (bits + 1) / 2;
  endfunction

endpackage

// File: rtl/fpd_slot_timer.sv
module fpd_slot_timer #(
  parameter int unsigned BITS         = 7,
  parameter int unsigned LOCK_PERIODS = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pd,
  output logic [$clog2(BITS)-1:0]  slot_o,
  output logic                     wrap_o,
  output logic                     fall_o,
  output logic                     pclk_o,
  output logic                     locked_o
);
  import fpd_ser_pkg::*;

  localparam int unsigned SLOT_W = $clog2(BITS);
  localparam int unsigned HIGH   = high_slots(BITS);
  localparam int unsigned LCK_W  = $clog2(LOCK_PERIODS + 1);

  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic              pclk_q;
  logic [LCK_W-1:0]  lcnt_q;
  logic              locked_q;

  assign wrap_o   = !pd && (slot_q == SLOT_W'(BITS - 1));
  assign fall_o   = !pd && (slot_q == SLOT_W'(HIGH - 1));
  assign slot_nxt = (slot_q == SLOT_W'(BITS - 1)) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      slot_q   <= '0;
      pclk_q   <= 1'b1;
      lcnt_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      slot_q <= slot_nxt;
      pclk_q <= (slot_nxt < SLOT_W'(HIGH));
      if (wrap_o && !locked_q) begin
        lcnt_q <= lcnt_q + 1'b1;
        if (lcnt_q == LCK_W'(LOCK_PERIODS - 1)) locked_q <= 1'b1;
      end
    end
  end

  assign slot_o   = slot_q;
  assign pclk_o   = pclk_q;
  assign locked_o = locked_q;

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot_q <= SLOT_W'(BITS - 1));

  // R7
  pclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk_q) |-> (slot_q == '0));

  // R7
  pclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pclk_q) |-> (slot_q == SLOT_W'(HIGH)));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !pd) |=> locked_q);

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> $past(wrap_o));

endmodule

// File: rtl/fpd_capture.sv
module fpd_capture #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd,
  input  logic              edge_sel,
  input  logic              at_rise,
  input  logic              at_fall,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_o
);
  import fpd_ser_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic              take;
  edge_mode_e        mode;

  assign mode = edge_mode_e'(edge_sel);
  assign take = (mode == EDGE_RISE) ? at_rise : at_fall;

  always_ff @(posedge clk) begin
    if (rst || pd)  word_q <= '0;
    else if (take)  word_q <= din;
  end

  assign word_o = word_q;

  // R5 R6
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd && !at_rise && !at_fall) |=> $stable(word_q));

  // R8
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    pd |=> (word_q == '0));

endmodule

// File: rtl/fpd_lane_shift.sv
module fpd_lane_shift #(
  parameter int unsigned BITS = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  output logic            ser_o
);
  logic [BITS-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  sreg_q <= '0;
    else if (load)   sreg_q <= load_val;
    else             sreg_q <= {1'b0, sreg_q[BITS-1:1]};
  end

  assign ser_o = sreg_q[0];

  // R2
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load) |=> (ser_o == $past(sreg_q[1])));

  // R2
  load_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load) |=> (ser_o == $past(load_val[0])));

endmodule

// File: rtl/fpd_link_serializer.sv
module fpd_link_serializer #(
  parameter int unsigned LANES        = 3,
  parameter int unsigned BITS         = 7,
  parameter int unsigned LOCK_PERIODS = 1024,
  parameter logic [6:0]  CLK_PAT      = 7'b1100011
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pd_i,
  input  logic                    edge_sel_i,
  input  logic [LANES*BITS-1:0]   pix_word_i,
  output logic [LANES-1:0]        data_lane_o,
  output logic                    clk_lane_o,
  output logic                    lane_oe_o,
  output logic                    pix_clk_o,
  output logic                    locked_o
);
  localparam int unsigned WORD_W = LANES * BITS;
  localparam int unsigned SLOT_W = $clog2(BITS);

  logic [SLOT_W-1:0] slot;
  logic              wrap, fall;
  logic [WORD_W-1:0] held_word;
  logic [BITS-1:0]   clk_frame;
  logic              oe_q;

  fpd_slot_timer #(
    .BITS         (BITS),
    .LOCK_PERIODS (LOCK_PERIODS)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .pd       (pd_i),
    .slot_o   (slot),
    .wrap_o   (wrap),
    .fall_o   (fall),
    .pclk_o   (pix_clk_o),
    .locked_o (locked_o)
  );

  fpd_capture #(
    .WORD_W (WORD_W)
  ) cap_i (
    .clk      (clk),
    .rst      (rst),
    .pd       (pd_i),
    .edge_sel (edge_sel_i),
    .at_rise  (wrap),
    .at_fall  (fall),
    .din      (pix_word_i),
    .word_o   (held_word)
  );

  // Clock pattern is written in time order; slot 0 must sit in bit 0.
  for (genvar i = 0; i < BITS; i++) begin : g_pat
    assign clk_frame[i] = CLK_PAT[BITS-1-i];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fpd_lane_shift #(
      .BITS (BITS)
    ) sh_i (
      .clk      (clk),
      .rst      (rst),
      .clr      (pd_i),
      .load     (wrap),
      .load_val (held_word[k*BITS +: BITS]),
      .ser_o    (data_lane_o[k])
    );
  end

  fpd_lane_shift #(
    .BITS (BITS)
  ) clk_sh_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (pd_i),
    .load     (wrap),
    .load_val (clk_frame),
    .ser_o    (clk_lane_o)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= !pd_i;
  end

  assign lane_oe_o = oe_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (data_lane_o == '0 && !clk_lane_o && !lane_oe_o && !locked_o && pix_clk_o));

  // R8
  powerdown_park_chk: assert property (@(posedge clk) disable iff (rst)
    pd_i |=> (!lane_oe_o && data_lane_o == '0 && !clk_lane_o && !locked_o));

  // R4
  clk_lane_start_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (clk_lane_o == CLK_PAT[BITS-1] && slot == '0));

  // R7
  frame_pclk_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> pix_clk_o);

endmodule

// File: tb/fpd_link_serializer_tb.sv
module fpd_link_serializer_tb_top;
  localparam int PERIOD = 10;
  localparam int LOCK   = 5;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pd  = 1'b0;
  logic        sel = 1'b0;
  logic [20:0] din = '0;
  logic [2:0]  lanes;
  logic        clane, oe, pclk, locked;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  // reference model state
  int          m_slot = 0;
  logic [20:0] m_cap  = '0;
  logic [20:0] m_tx   = '0;
  bit          m_cval = 0;
  int          m_lcnt = 0;
  bit          m_lock = 0;
  bit          m_oe   = 0;
  bit          m_pclk = 1;

  always #(PERIOD/2) clk = ~clk;

  fpd_link_serializer #(.LOCK_PERIODS(LOCK)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .pd_i        (pd),
    .edge_sel_i  (sel),
    .pix_word_i  (din),
    .data_lane_o (lanes),
    .clk_lane_o  (clane),
    .lane_oe_o   (oe),
    .pix_clk_o   (pclk),
    .locked_o    (locked)
  );

  always @(posedge clk) begin
    if (rst || pd) begin
      m_slot = 0; m_cap = '0; m_tx = '0; m_cval = 0;
      m_lcnt = 0; m_lock = 0; m_pclk = 1;
      m_oe = !rst && !pd;
    end else begin
      if (m_slot == 6) begin
        m_tx = m_cap;
        m_cval = 1;
        if (!m_lock) begin
          m_lcnt++;
          if (m_lcnt == LOCK) m_lock = 1;
        end
      end
      if ((sel == 1'b0 && m_slot == 6) || (sel == 1'b1 && m_slot == 3)) m_cap = din;
      m_slot = (m_slot == 6) ? 0 : m_slot + 1;
      m_pclk = (m_slot < 4);
      m_oe = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [2:0] e_lanes;
    logic       e_clk;
    for (int k = 0; k < 3; k++) e_lanes[k] = m_tx[7*k + m_slot];
    e_clk = m_cval ? PAT[6 - m_slot] : 1'b0;
    chk(lanes == e_lanes, sel ? "R2 R3 R6 data lanes" : "R2 R3 R5 data lanes",
        int'(lanes), int'(e_lanes));
    chk(clane == e_clk, "R4 clock lane", int'(clane), int'(e_clk));
    chk(pclk == m_pclk, "R7 pixel clock", int'(pclk), int'(m_pclk));
    chk(oe == m_oe, "R8 output enable", int'(oe), int'(m_oe));
    chk(locked == m_lock, "R9 locked", int'(locked), int'(m_lock));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      din = 21'($urandom());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lanes == 3'b000 && !clane && !oe && !locked && pclk, "R1 reset state",
        int'({lanes, clane, oe, locked, pclk}), 1);
    rst = 1'b0;
    run(300);
    pd = 1'b1;        // R8
    run(12);
    pd = 1'b0;
    run(120);
    sel = 1'b1;       // R6 falling capture
    run(300);
    pd = 1'b1;        // R8 single-cycle pulse
    run(1);
    pd = 1'b0;
    run(90);
    sel = 1'b0;
    rst = 1'b1;       // R1 mid-run reset
    run(3);
    rst = 1'b0;
    run(150);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule